// File: doc/BRIEF.md
# Keyboard Controller Interrupt Output Mux

This block drives the two host interrupt lines of a legacy keyboard-controller interface: one for keyboard data and one for auxiliary (mouse) data. Each line carries an output-buffer-full indication. That indication comes from one of two sources. The first is a hardware flag that a controller write to a data register sets and a host read of the data register clears. The second is a latch that firmware writes directly. A per-line select bit picks the source. A global enable forces both lines low.

The embedded controller reaches the block through a small register port. The port has a write strobe, an address, write data and combinational read data. The host side gives a single-cycle strobe for each read of the host data register, and the block presents the byte most recently written by the controller. Both interrupt outputs come from flops. A register write changes a line at the same clock edge that captures the write, so the line never glitches between edges.

Top module: `kbc_irq_mux`

## Requirements
- R1: When the global enable (control register, address 4, bit 0) is 0, both `kbd_irq` and `aux_irq` are low, whatever the other settings are.
- R2: With enable 1 and keyboard select (address 4, bit 1) at 0, `kbd_irq` follows the keyboard hardware flag. A controller write to address 0 sets that flag, and `kbd_irq` rises at the edge that captures the write.
- R3: A `host_data_rd` pulse clears the keyboard hardware flag at that clock edge.
- R4: When a controller data write and a `host_data_rd` pulse fall in the same cycle, the flag of the written channel ends up set.
- R5: With enable 1 and auxiliary select (address 4, bit 2) at 0, `aux_irq` follows the auxiliary hardware flag. A write to address 1 sets that flag and a `host_data_rd` pulse clears it.
- R6: With keyboard select at 1, `kbd_irq` follows a firmware latch. Writing bit 0 of address 3 loads the latch, and `host_data_rd` leaves it unchanged.
- R7: With auxiliary select at 1, `aux_irq` follows a firmware latch. Writing bit 5 of the status register (address 2) sets or clears the latch, and `host_data_rd` never clears it.
- R8: Bit 0 of address 3 and bit 0 of address 2 read back the selected keyboard source. Bit 5 of address 2 reads back the selected auxiliary source. Address 4 reads back its three control bits. Addresses 0 and 1 read back the data byte. Every other bit and address reads 0.
- R9: The hardware flags keep tracking writes and reads while firmware is selected. A change of select or enable takes effect on the outputs at the edge that captures the control write.
- R10: After reset, all flags, latches, control bits and the data byte are 0, and both interrupt lines are low.
- R11: Writes to status bit 0 and to status bits other than 5 have no effect on any flag or output.
- R12: `host_rdata` holds the byte from the most recent controller write to address 0 or address 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ec_wr | input | 1 | Controller register write strobe |
| ec_addr | input | 3 | Controller register address |
| ec_wdata | input | 8 | Controller write data |
| ec_rdata | output | 8 | Controller read data (combinational) |
| host_data_rd | input | 1 | One-cycle pulse for each host read of the data register |
| host_rdata | output | 8 | Byte presented to the host |
| kbd_irq | output | 1 | Keyboard interrupt line |
| aux_irq | output | 1 | Auxiliary interrupt line |

## Verification
The hardest cases to reach are a data write and a host read landing in the same cycle, and a hardware flag that has moved while firmware owned the line, so that it appears only when the select bit goes back. The stimulus drives `ec_wr` and `host_data_rd` together in directed steps. It sets a flag under firmware select, clears or sets it underneath, and then flips the select. A long pseudo-random run then mixes all addresses, write data and read pulses. The behavioural model is compared on every clock.

// File: rtl/kbc_irq_pkg.sv
package kbc_irq_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;

  // register addresses
  localparam int A_KDATA  = 0;
  localparam int A_ADATA  = 1;
  localparam int A_STAT   = 2;
  localparam int A_KLATCH = 3;
  localparam int A_CTRL   = 4;

  // bit positions
  localparam int ST_KBD_BIT = 0;
  localparam int ST_AUX_BIT = 5;
  localparam int KL_BIT     = 0;

  // channel indices
  localparam int CH_KBD = 0;
  localparam int CH_AUX = 1;
  localparam int NCH    = 2;

  typedef struct packed {
    logic asel;
    logic ksel;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/kbc_rst_sync.sv
module kbc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/kbc_ec_regs.sv
module kbc_ec_regs
  import kbc_irq_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ec_wr,
  input  logic [AW-1:0]  ec_addr,
  input  logic [DW-1:0]  ec_wdata,
  output ctrl_t          ctrl_q,
  output ctrl_t          ctrl_d,
  output logic [NCH-1:0] fw_q,
  output logic [NCH-1:0] fw_d,
  output logic [NCH-1:0] hw_set,
  output logic [DW-1:0]  data_q
);
  logic          ctrl_we;
  logic [NCH-1:0] fw_we;
  logic          data_we;
  logic [DW-1:0] data_d;

  // decode: next state and write enables
  always_comb begin
    ctrl_d  = ctrl_q;
    fw_d    = fw_q;
    data_d  = data_q;
    hw_set  = '0;
    ctrl_we = 1'b0;
    fw_we   = '0;
    data_we = 1'b0;
    if (ec_wr) begin
      case (ec_addr)
        AW'(A_KDATA): begin
          hw_set[CH_KBD] = 1'b1;
          data_we        = 1'b1;
          data_d         = ec_wdata;
        end
        AW'(A_ADATA): begin
          hw_set[CH_AUX] = 1'b1;
          data_we        = 1'b1;
          data_d         = ec_wdata;
        end
        AW'(A_STAT): begin
          fw_we[CH_AUX] = 1'b1;
          fw_d[CH_AUX]  = ec_wdata[ST_AUX_BIT];
        end
        AW'(A_KLATCH): begin
          fw_we[CH_KBD] = 1'b1;
          fw_d[CH_KBD]  = ec_wdata[KL_BIT];
        end
        AW'(A_CTRL): begin
          ctrl_we = 1'b1;
          ctrl_d  = ctrl_t'(ec_wdata[2:0]);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_we) begin
      ctrl_q <= ctrl_d;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_fw
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        fw_q[c] <= 1'b0;
      end else if (fw_we[c]) begin
        fw_q[c] <= fw_d[c];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (data_we) begin
      data_q <= data_d;
    end
  end
endmodule

// File: rtl/kbc_obf_flag.sv
module kbc_obf_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag_d,
  output logic flag_q
);
  logic flag_we;

  // set has priority over clear
  always_comb begin
    flag_we = set | clr;
    flag_d  = set | (flag_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (flag_we) begin
      flag_q <= flag_d;
    end
  end
endmodule

// File: rtl/kbc_irq_drive.sv
module kbc_irq_drive (
  input  logic clk,
  input  logic rst_n,
  input  logic en_d,
  input  logic sel_d,
  input  logic hw_d,
  input  logic fw_d,
  output logic irq_q
);
  logic irq_d;

  // built from next-state values so a control write lands on its own edge
  always_comb begin
    irq_d = en_d & (sel_d ? fw_d : hw_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end
endmodule

// File: rtl/kbc_irq_mux.sv
module kbc_irq_mux
  import kbc_irq_pkg::*;
#(
  parameter int AW          = ADDR_W,
  parameter int DW          = DATA_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ec_wr,
  input  logic [AW-1:0] ec_addr,
  input  logic [DW-1:0] ec_wdata,
  output logic [DW-1:0] ec_rdata,
  input  logic          host_data_rd,
  output logic [DW-1:0] host_rdata,
  output logic          kbd_irq,
  output logic          aux_irq
);
  logic           srst_n;
  ctrl_t          ctrl_q;
  ctrl_t          ctrl_d;
  logic [NCH-1:0] fw_q;
  logic [NCH-1:0] fw_d;
  logic [NCH-1:0] hw_set;
  logic [NCH-1:0] hw_d;
  logic [NCH-1:0] hw_q;
  logic [NCH-1:0] sel_d;
  logic [NCH-1:0] irq_q;
  logic [NCH-1:0] src_q;
  logic [DW-1:0]  data_q;

  kbc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  kbc_ec_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk      (clk),
    .rst_n    (srst_n),
    .ec_wr    (ec_wr),
    .ec_addr  (ec_addr),
    .ec_wdata (ec_wdata),
    .ctrl_q   (ctrl_q),
    .ctrl_d   (ctrl_d),
    .fw_q     (fw_q),
    .fw_d     (fw_d),
    .hw_set   (hw_set),
    .data_q   (data_q)
  );

  assign sel_d[CH_KBD] = ctrl_d.ksel;
  assign sel_d[CH_AUX] = ctrl_d.asel;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    kbc_obf_flag u_flag (
      .clk    (clk),
      .rst_n  (srst_n),
      .set    (hw_set[c]),
      .clr    (host_data_rd),
      .flag_d (hw_d[c]),
      .flag_q (hw_q[c])
    );

    kbc_irq_drive u_drv (
      .clk   (clk),
      .rst_n (srst_n),
      .en_d  (ctrl_d.en),
      .sel_d (sel_d[c]),
      .hw_d  (hw_d[c]),
      .fw_d  (fw_d[c]),
      .irq_q (irq_q[c])
    );
  end

  // selected source per channel, for read-back
  always_comb begin
    src_q[CH_KBD] = ctrl_q.ksel ? fw_q[CH_KBD] : hw_q[CH_KBD];
    src_q[CH_AUX] = ctrl_q.asel ? fw_q[CH_AUX] : hw_q[CH_AUX];
  end

  always_comb begin
    ec_rdata = '0;
    case (ec_addr)
      AW'(A_KDATA), AW'(A_ADATA): ec_rdata = data_q;
      AW'(A_STAT): begin
        ec_rdata[ST_KBD_BIT] = src_q[CH_KBD];
        ec_rdata[ST_AUX_BIT] = src_q[CH_AUX];
      end
      AW'(A_KLATCH): ec_rdata[KL_BIT] = src_q[CH_KBD];
      AW'(A_CTRL):   ec_rdata[2:0]    = ctrl_q;
      default: ;
    endcase
  end

  assign host_rdata = data_q;
  assign kbd_irq    = irq_q[CH_KBD];
  assign aux_irq    = irq_q[CH_AUX];
endmodule

// File: rtl/kbc_irq_mux_chk.sv
module kbc_irq_mux_chk
  import kbc_irq_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input logic           clk,
  input logic           srst_n,
  input ctrl_t          ctrl_q,
  input logic [NCH-1:0] hw_q,
  input logic [NCH-1:0] fw_q,
  input logic           ec_wr,
  input logic [AW-1:0]  ec_addr,
  input logic           host_data_rd,
  input logic           kbd_irq,
  input logic           aux_irq
);
  logic wr_k, wr_a, wr_st, wr_kl;
  assign wr_k  = ec_wr && (ec_addr == AW'(A_KDATA));
  assign wr_a  = ec_wr && (ec_addr == AW'(A_ADATA));
  assign wr_st = ec_wr && (ec_addr == AW'(A_STAT));
  assign wr_kl = ec_wr && (ec_addr == AW'(A_KLATCH));

  a_r1_disabled_quiet: assert property (@(posedge clk) disable iff (!srst_n)
    !ctrl_q.en |-> (!kbd_irq && !aux_irq));

  a_r2_kbd_hw_follow: assert property (@(posedge clk) disable iff (!srst_n)
    (ctrl_q.en && !ctrl_q.ksel) |-> (kbd_irq == hw_q[CH_KBD]));

  a_r3_hostrd_clears: assert property (@(posedge clk) disable iff (!srst_n)
    (host_data_rd && !wr_k) |=> !hw_q[CH_KBD]);

  a_r4_write_wins: assert property (@(posedge clk) disable iff (!srst_n)
    (host_data_rd && wr_a) |=> hw_q[CH_AUX]);

  a_r5_aux_hw_follow: assert property (@(posedge clk) disable iff (!srst_n)
    (ctrl_q.en && !ctrl_q.asel) |-> (aux_irq == hw_q[CH_AUX]));

  a_r6_kbd_fw_follow: assert property (@(posedge clk) disable iff (!srst_n)
    (ctrl_q.en && ctrl_q.ksel) |-> (kbd_irq == fw_q[CH_KBD]));

  a_r7_aux_fw_holds: assert property (@(posedge clk) disable iff (!srst_n)
    (host_data_rd && !wr_st) |=> $stable(fw_q[CH_AUX]));

  a_r6_kbd_latch_holds: assert property (@(posedge clk) disable iff (!srst_n)
    (host_data_rd && !wr_kl) |=> $stable(fw_q[CH_KBD]));
endmodule

bind kbc_irq_mux kbc_irq_mux_chk #(.AW(AW)) u_chk (
  .clk          (clk),
  .srst_n       (srst_n),
  .ctrl_q       (ctrl_q),
  .hw_q         (hw_q),
  .fw_q         (fw_q),
  .ec_wr        (ec_wr),
  .ec_addr      (ec_addr),
  .host_data_rd (host_data_rd),
  .kbd_irq      (kbd_irq),
  .aux_irq      (aux_irq)
);

// File: tb/kbc_irq_mux_test.sv
`timescale 1ns/1ps
module kbc_irq_mux_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ec_wr = 1'b0;
  logic [2:0] ec_addr = '0;
  logic [7:0] ec_wdata = '0;
  logic [7:0] ec_rdata;
  logic       host_data_rd = 1'b0;
  logic [7:0] host_rdata;
  logic       kbd_irq, aux_irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // reference state
  bit m_en, m_ks, m_as, m_khw, m_ahw, m_kfw, m_afw;
  logic [7:0] m_data;

  always #2 clk = ~clk;

  kbc_irq_mux uut (
    .clk(clk), .rst_n(rst_n), .ec_wr(ec_wr), .ec_addr(ec_addr),
    .ec_wdata(ec_wdata), .ec_rdata(ec_rdata), .host_data_rd(host_data_rd),
    .host_rdata(host_rdata), .kbd_irq(kbd_irq), .aux_irq(aux_irq)
  );

  task automatic chk(input string tag, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_en = 0; m_ks = 0; m_as = 0; m_khw = 0; m_ahw = 0;
    m_kfw = 0; m_afw = 0; m_data = '0;
  endtask

  function automatic logic [7:0] exp_rd(input logic [2:0] a);
    logic [7:0] r;
    bit kf, af;
    kf = m_ks ? m_kfw : m_khw;
    af = m_as ? m_afw : m_ahw;
    r = '0;
    case (a)
      3'd0, 3'd1: r = m_data;
      3'd2: begin r[0] = kf; r[5] = af; end
      3'd3: r[0] = kf;
      3'd4: r = {5'b0, m_as, m_ks, m_en};
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic compare_all(input string tag);
    chk(tag, "kbd_irq", {7'b0, kbd_irq}, {7'b0, m_en & (m_ks ? m_kfw : m_khw)});
    chk(tag, "aux_irq", {7'b0, aux_irq}, {7'b0, m_en & (m_as ? m_afw : m_ahw)});
    chk(tag, "ec_rdata", ec_rdata, exp_rd(ec_addr));
    chk(tag, "host_rdata", host_rdata, m_data);
  endtask

  // one clock: drive at negedge, update model at posedge, compare after
  task automatic cyc(input string tag, input bit wr, input logic [2:0] a,
                     input logic [7:0] d, input bit hrd);
    bit ks_set, as_set;
    @(negedge clk);
    ec_wr = wr; ec_addr = a; ec_wdata = d; host_data_rd = hrd;
    @(posedge clk);
    ks_set = wr && a == 3'd0;
    as_set = wr && a == 3'd1;
    m_khw = ks_set ? 1'b1 : (hrd ? 1'b0 : m_khw);
    m_ahw = as_set ? 1'b1 : (hrd ? 1'b0 : m_ahw);
    if (ks_set || as_set) m_data = d;
    if (wr && a == 3'd2) m_afw = d[5];
    if (wr && a == 3'd3) m_kfw = d[0];
    if (wr && a == 3'd4) begin m_en = d[0]; m_ks = d[1]; m_as = d[2]; end
    #1;
    compare_all(tag);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    // R10: reset state
    ec_addr = 3'd4;
    #1 compare_all("R10");
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1 compare_all("R10");

    // R1: disabled, data written, lines stay low
    cyc("R1", 1, 3'd0, 8'h3c, 0);
    cyc("R1", 1, 3'd1, 8'h5a, 0);
    cyc("R12", 0, 3'd0, 8'h00, 0);
    // enable: lines rise on the control write edge (R9)
    cyc("R9", 1, 3'd4, 8'h01, 0);
    cyc("R8", 0, 3'd2, 8'h00, 0);
    // R3 / R5: host read clears both
    cyc("R3", 0, 3'd2, 8'h00, 1);
    // R2: keyboard hw set
    cyc("R2", 1, 3'd0, 8'h11, 0);
    // R4: write and read together
    cyc("R4", 1, 3'd1, 8'h22, 1);
    cyc("R4", 1, 3'd0, 8'h33, 1);
    cyc("R5", 0, 3'd2, 8'h00, 1);
    // R6: keyboard firmware latch
    cyc("R6", 1, 3'd4, 8'h03, 0);
    cyc("R6", 1, 3'd3, 8'h01, 0);
    cyc("R6", 0, 3'd3, 8'h00, 1);
    cyc("R9", 1, 3'd0, 8'h44, 0);
    cyc("R6", 1, 3'd3, 8'h00, 0);
    // R9: hw flag set underneath is revealed on select switch
    cyc("R9", 1, 3'd4, 8'h01, 0);
    // R7: aux firmware latch
    cyc("R7", 1, 3'd4, 8'h05, 0);
    cyc("R7", 1, 3'd2, 8'h20, 0);
    cyc("R7", 0, 3'd2, 8'h00, 1);
    // R11: status bit 0 and other bits ignored
    cyc("R11", 1, 3'd2, 8'hdf, 0);
    cyc("R11", 1, 3'd2, 8'h21, 0);
    cyc("R7", 1, 3'd2, 8'h00, 0);
    // R8: unused addresses read zero
    cyc("R8", 1, 3'd6, 8'hff, 0);
    cyc("R8", 0, 3'd7, 8'h00, 0);
    // R1: disable with everything set
    cyc("R1", 1, 3'd2, 8'h20, 0);
    cyc("R1", 1, 3'd4, 8'h06, 0);

    // mixed pseudo-random traffic
    for (int i = 0; i < 600; i++) begin
      cyc("R8", ($urandom % 3) != 0, 3'($urandom % 7), 8'($urandom),
          ($urandom % 4) == 0);
    end

    // R10: asynchronous reset mid-run
    @(negedge clk) rst_n = 1'b0;
    model_reset();
    #1 compare_all("R10");
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    cyc("R10", 0, 3'd4, 8'h00, 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule